// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh and Start-Up Sequencer

This block sits beside the access controller of a pseudo-static RAM. It owns two jobs the memory needs from its host. The first is the start-up routine. After reset it keeps the memory untouched for a configurable pause, and it keeps the refresh strobe inactive during that pause. It then asks for a fixed number of throw-away access cycles. The second is periodic refresh. Once started, a free-running timer asks for one refresh per interval, which spreads the 512 row refreshes evenly over the 8 ms retention window.

The access controller answers every request with a one-cycle grant. A parameter picks how each refresh is carried out. In address mode, the grant means that the controller has just run a chip-enable-only cycle on the row that `ref_row` presents. The row counter then advances. In strobe mode, the grant hands the cycle to this block. It waits a lead time, drives the active-low refresh strobe for a bounded width, and then waits a recovery time. During that whole window it tells the controller to keep chip-enable inactive.

Refreshes that are not granted in time are counted as debt. They are then requested back to back. Host traffic is gated until start-up is complete, and while a strobe sequence is running.

Top module: `psram_refresh_seq`

## Requirements
- R1: While reset is asserted, `init_done`, `ref_req`, `ref_dummy`, `host_ok` and `mem_hold` are 0, `rfsh_n` is 1 and `ref_row` is 0.
- R2: After reset is released, `ref_req` stays 0 for exactly PAUSE_CYC clock cycles, and it is 1 in the cycle that follows. `rfsh_n` stays 1 and `init_done` stays 0 for the whole pause.
- R3: After the pause, `ref_req` and `ref_dummy` are held at 1 until DUMMY_CNT grants have been taken, where a grant is `ref_req` and `ref_gnt` both 1 at a clock edge. `init_done` becomes 1 right after the last of these grants and stays 1 until the next reset.
- R4: `host_ok` equals `host_req` when `init_done` is 1 and `mem_hold` is 0; otherwise it is 0.
- R5: Once `init_done` is 1, one refresh is requested every INTERVAL_CYC cycles. The first request appears INTERVAL_CYC cycles after `init_done` rises.
- R6: A raised `ref_req` stays 1 until a grant is taken.
- R7: Refresh intervals that expire before the pending request is granted are accumulated, up to a ceiling of 2**DEBT_W-1 outstanding refreshes. With the grant held at 1, these are requested in back-to-back cycles, one per cycle, until none remain.
- R8: In address mode (PIN_MODE=0), `ref_row` (ROW_W bits, 9 by default) increments by one after each refresh grant and wraps from its maximum to 0. Start-up cycles do not move it.
- R9: In strobe mode (PIN_MODE=1), a refresh grant starts the following sequence. First, LEAD_CYC cycles with `rfsh_n`=1. Then LOW_CYC cycles with `rfsh_n`=0. Then TAIL_CYC cycles with `rfsh_n`=1. `mem_hold` is 1 over all of these cycles and `ref_req` is 0 during them.
- R10: In strobe mode, `ref_row` stays 0, and start-up cycles do not pulse `rfsh_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host wants to start an access |
| host_ok | output | 1 | Host access allowed this cycle |
| ref_req | output | 1 | Start-up or refresh cycle requested |
| ref_gnt | input | 1 | Controller accepts the requested cycle |
| ref_dummy | output | 1 | Current request is a start-up cycle |
| ref_row | output | ROW_W | Row for a chip-enable-only refresh |
| rfsh_n | output | 1 | Active-low refresh strobe to the memory |
| mem_hold | output | 1 | Controller must keep chip-enable inactive |
| init_done | output | 1 | Start-up sequence complete |

## Verification
The checker watches the invariants on every cycle. These are: a request is held until it is granted; `init_done` never falls; the strobe is low only inside a hold window; no request is raised while a hold is active; and the row steps by one on each address-mode grant. Some properties depend on counted intervals, so only the bench scenarios can show them. These are: the exact pause length, the number of start-up cycles, the spacing of refresh requests, the debt count at each length of withheld grant including the ceiling, and the placement and width of the strobe within its window.

// File: rtl/psram_refresh_seq.sv
module psram_refresh_seq #(
  parameter int PAUSE_CYC    = 5000,
  parameter int DUMMY_CNT    = 8,
  parameter int INTERVAL_CYC = 700,
  parameter int ROW_W        = 9,
  parameter int DEBT_W       = 2,
  parameter int PIN_MODE     = 0,
  parameter int LEAD_CYC     = 3,
  parameter int LOW_CYC      = 4,
  parameter int TAIL_CYC     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  output logic             host_ok,
  output logic             ref_req,
  input  logic             ref_gnt,
  output logic             ref_dummy,
  output logic [ROW_W-1:0] ref_row,
  output logic             rfsh_n,
  output logic             mem_hold,
  output logic             init_done
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int DW = $clog2(DUMMY_CNT + 1);
  localparam int TW = $clog2(INTERVAL_CYC + 1);
  localparam int SMAX = (LEAD_CYC > LOW_CYC) ? ((LEAD_CYC > TAIL_CYC) ? LEAD_CYC : TAIL_CYC)
                                             : ((LOW_CYC > TAIL_CYC) ? LOW_CYC : TAIL_CYC);
  localparam int SW = $clog2(SMAX + 1);
  localparam logic [DEBT_W-1:0] DEBT_MAX = '1;

  typedef enum logic [1:0] {ST_PAUSE, ST_DUMMY, ST_RUN} st_t;

  st_t st;
  logic [PW-1:0] pcnt;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] tmr;
  logic [DEBT_W-1:0] pend;
  logic run, tick, take;

  assign run       = (st == ST_RUN);
  assign take      = ref_req & ref_gnt;
  assign tick      = run && (tmr == TW'(INTERVAL_CYC - 1));
  assign init_done = run;
  assign ref_dummy = (st == ST_DUMMY);
  assign ref_req   = ref_dummy | (run & (pend != '0) & ~mem_hold);
  assign host_ok   = host_req & run & ~mem_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_PAUSE;
      pcnt <= '0;
      dcnt <= '0;
    end else begin
      case (st)
        ST_PAUSE:
          if (pcnt == PW'(PAUSE_CYC - 1)) st <= ST_DUMMY;
          else pcnt <= pcnt + PW'(1);
        ST_DUMMY:
          if (take) begin
            if (dcnt == DW'(DUMMY_CNT - 1)) st <= ST_RUN;
            else dcnt <= dcnt + DW'(1);
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) tmr <= '0;
    else if (tick) tmr <= '0;
    else tmr <= tmr + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pend <= '0;
    else if (tick && !take && pend != DEBT_MAX) pend <= pend + DEBT_W'(1);
    else if (take && !tick) pend <= pend - DEBT_W'(1);
  end

  generate
    if (PIN_MODE != 0) begin : g_strobe
      typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_LOW, PH_TAIL} ph_t;
      ph_t ph;
      logic [SW-1:0] sc;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ph <= PH_IDLE;
          sc <= '0;
        end else begin
          case (ph)
            PH_IDLE: if (take && run) begin ph <= PH_LEAD; sc <= '0; end
            PH_LEAD:
              if (sc == SW'(LEAD_CYC - 1)) begin ph <= PH_LOW; sc <= '0; end
              else sc <= sc + SW'(1);
            PH_LOW:
              if (sc == SW'(LOW_CYC - 1)) begin ph <= PH_TAIL; sc <= '0; end
              else sc <= sc + SW'(1);
            default:
              if (sc == SW'(TAIL_CYC - 1)) begin ph <= PH_IDLE; sc <= '0; end
              else sc <= sc + SW'(1);
          endcase
        end
      end

      assign rfsh_n   = (ph != PH_LOW);
      assign mem_hold = (ph != PH_IDLE);
      assign ref_row  = '0;
    end else begin : g_addr
      logic [ROW_W-1:0] row;

      always_ff @(posedge clk) begin
        if (!rst_n) row <= '0;
        else if (take && run) row <= row + ROW_W'(1);
      end

      assign ref_row  = row;
      assign rfsh_n   = 1'b1;
      assign mem_hold = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/psram_refresh_seq_chk.sv
module psram_refresh_seq_chk #(
  parameter int ROW_W    = 9,
  parameter int PIN_MODE = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             host_ok,
  input logic             ref_req,
  input logic             ref_gnt,
  input logic [ROW_W-1:0] ref_row,
  input logic             rfsh_n,
  input logic             mem_hold,
  input logic             init_done
);
  p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_quiet_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (rfsh_n && !mem_hold));

  p_host_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_ok |-> (init_done && host_req));

  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);

  p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (PIN_MODE == 0 && init_done && ref_req && ref_gnt) |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

  p_strobe_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> mem_hold);

  p_no_req_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hold |-> !ref_req);

  p_hold_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (PIN_MODE != 0 && init_done && ref_req && ref_gnt) |=> (mem_hold && rfsh_n));
endmodule

bind psram_refresh_seq psram_refresh_seq_chk #(.ROW_W(ROW_W), .PIN_MODE(PIN_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ok(host_ok),
  .ref_req(ref_req), .ref_gnt(ref_gnt), .ref_row(ref_row), .rfsh_n(rfsh_n),
  .mem_hold(mem_hold), .init_done(init_done));

// File: tb/psram_refresh_seq_test.sv
module psram_refresh_seq_test;
  localparam int PAUSE = 20, DUMMY = 3, INTV = 16, RW = 4, DBW = 2;
  localparam int LEAD = 2, LOW = 3, TAIL = 2;
  localparam int DMAX = (1 << DBW) - 1;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_a, hreq_a, hok_a, req_a, gnt_a, dum_a, rf_a, hold_a, done_a;
  logic [RW-1:0] row_a;
  logic rst_b, hreq_b, hok_b, req_b, gnt_b, dum_b, rf_b, hold_b, done_b;
  logic [RW-1:0] row_b;

  psram_refresh_seq #(.PAUSE_CYC(PAUSE), .DUMMY_CNT(DUMMY), .INTERVAL_CYC(INTV), .ROW_W(RW),
    .DEBT_W(DBW), .PIN_MODE(0)) uut (
    .clk(clk), .rst_n(rst_a), .host_req(hreq_a), .host_ok(hok_a), .ref_req(req_a),
    .ref_gnt(gnt_a), .ref_dummy(dum_a), .ref_row(row_a), .rfsh_n(rf_a),
    .mem_hold(hold_a), .init_done(done_a));

  psram_refresh_seq #(.PAUSE_CYC(PAUSE), .DUMMY_CNT(DUMMY), .INTERVAL_CYC(INTV), .ROW_W(RW),
    .DEBT_W(DBW), .PIN_MODE(1), .LEAD_CYC(LEAD), .LOW_CYC(LOW), .TAIL_CYC(TAIL)) uut_pin (
    .clk(clk), .rst_n(rst_b), .host_req(hreq_b), .host_ok(hok_b), .ref_req(req_b),
    .ref_gnt(gnt_b), .ref_dummy(dum_b), .ref_row(row_b), .rfsh_n(rf_b),
    .mem_hold(hold_b), .init_done(done_b));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n, g, k, exp_row, last, exp_k;
    rst_a = 0; rst_b = 0; hreq_a = 1; hreq_b = 1; gnt_a = 0; gnt_b = 0;
    step(); step(); step();
    // R1 reset state
    chk(done_a == 0 && req_a == 0 && dum_a == 0 && hok_a == 0 && hold_a == 0, "R1 outputs idle", req_a, 0);
    chk(rf_a == 1 && row_a == 0, "R1 strobe high, row zero", row_a, 0);

    // ---- address mode ----
    rst_a = 1;
    n = 0;
    while (!req_a && n < 1000) begin
      step(); n++;
      if (!req_a) chk(rf_a && !done_a && !hok_a, "R2 quiet during pause", done_a, 0);
    end
    chk(n == PAUSE, "R2 pause length", n, PAUSE);

    g = 0;
    while (!done_a && g < 50) begin
      chk(req_a && dum_a, "R3 dummy request shown", dum_a, 1);
      chk(!hok_a, "R4 host blocked in start-up", hok_a, 0);
      gnt_a = 1; step(); gnt_a = 0; g++;
    end
    chk(g == DUMMY, "R3 start-up cycle count", g, DUMMY);
    chk(row_a == 0, "R8 row unmoved by start-up", row_a, 0);
    chk(hok_a == 1 && req_a == 0 && dum_a == 0, "R4 host allowed after start-up", hok_a, 1);

    exp_row = 0;
    last = cyc;
    for (int i = 0; i < 20; i++) begin
      n = 0;
      while (!req_a && n < 100) begin step(); n++; end
      chk(cyc - last == INTV, "R5 refresh spacing", cyc - last, INTV);
      last = cyc;
      if (i == 0) begin
        for (int h = 0; h < 5; h++) begin
          step();
          chk(req_a == 1, "R6 request held without grant", req_a, 1);
        end
      end
      gnt_a = 1; step(); gnt_a = 0;
      exp_row = (exp_row + 1) % (1 << RW);
      chk(row_a == exp_row, "R8 row step and wrap", row_a, exp_row);
    end

    for (int extra = 0; extra <= 4; extra++) begin
      n = 0;
      while (!req_a && n < 100) begin step(); n++; end
      repeat (extra * INTV + 2) step();
      exp_k = (1 + extra > DMAX) ? DMAX : 1 + extra;
      gnt_a = 1; k = 0;
      while (req_a && k < 20) begin step(); k++; end
      gnt_a = 0;
      chk(k == exp_k, "R7 debt drained back to back", k, exp_k);
      exp_row = (exp_row + exp_k) % (1 << RW);
      chk(row_a == exp_row, "R8 row after debt drain", row_a, exp_row);
    end

    // ---- strobe mode ----
    rst_a = 0;
    rst_b = 1;
    n = 0;
    while (!req_b && n < 1000) begin
      step(); n++;
      if (!req_b) chk(rf_b && !done_b && !hold_b, "R2 strobe idle during pause", rf_b, 1);
    end
    chk(n == PAUSE, "R2 pause length strobe mode", n, PAUSE);
    g = 0;
    while (!done_b && g < 50) begin
      gnt_b = 1; step(); gnt_b = 0; g++;
      chk(rf_b && !hold_b, "R10 no strobe for start-up cycle", rf_b, 1);
    end
    chk(g == DUMMY, "R3 start-up count strobe mode", g, DUMMY);

    for (int r = 0; r < 3; r++) begin
      n = 0;
      while (!req_b && n < 100) begin step(); n++; end
      chk(req_b == 1, "R5 strobe-mode request", req_b, 1);
      gnt_b = 1; step(); gnt_b = 0;
      for (int s = 1; s <= LEAD + LOW + TAIL + 2; s++) begin
        bit exp_hold, exp_low;
        exp_hold = (s <= LEAD + LOW + TAIL);
        exp_low  = (s > LEAD) && (s <= LEAD + LOW);
        chk(hold_b == exp_hold, "R9 hold window", hold_b, exp_hold);
        chk(rf_b == !exp_low, "R9 strobe placement", rf_b, !exp_low);
        if (exp_hold) begin
          chk(req_b == 0, "R9 no request in hold", req_b, 0);
          chk(hok_b == 0, "R4 host blocked in hold", hok_b, 0);
        end else begin
          chk(hok_b == 1, "R4 host allowed after hold", hok_b, 1);
        end
        chk(row_b == 0, "R10 row fixed in strobe mode", row_b, 0);
        if (s < LEAD + LOW + TAIL + 2) step();
      end
    end
    finish_run();
  end
endmodule